// File: doc/BRIEF.md
# Wavefront Instruction Fetch Buffer

This block holds the instruction stream of one wavefront as a small ring of cache-line slots. It asks the memory side for the next line whenever a slot is free. Each request carries an epoch tag. The slot stays reserved until the matching fill arrives, and then becomes buffered. A byte-granular read pointer hands 32-bit little-endian instruction words to the downstream instruction buffer. That pointer need not be word aligned. A word may therefore span two slots, including the last slot and the first slot of the physical array.

Slots are freed in address order, and only when the wavefront program counter has moved past the end of the oldest buffered line. Reading a line does not free it. A flush with a redirect address discards every reservation and every buffered line. It moves the read pointer to the new address and advances the epoch. Fills that come back later for the discarded requests are recognised by their stale tag and dropped. Line number `n` always lives in slot `n mod DEPTH`, so a byte address selects its physical byte directly.

Top module: `wf_fetch_buf`

## Requirements
- R1: After reset the occupancy and buffered byte count are 0, `req_valid` is 1 with `req_addr` 0 and `req_tag` 0, and `word_valid`, `has_data` and `order_err` are 0.
- R2: `req_valid` is 1 exactly when occupancy is below DEPTH. `req_addr` is the line after the newest reserved or buffered line. A handshake (`req_valid && req_ready`) without flush reserves one slot.
- R3: A fill is accepted when all of the following hold: its tag equals the current epoch, a reservation exists, and `fill_addr[AW-1:log2(LINE_BYTES)]` equals the line number of the oldest reservation. The slot then becomes buffered with `fill_data`, where byte k of the line sits in bits [8k+7:8k].
- R4: A fill with the current tag that is not accepted raises `order_err` for one cycle, starting the next cycle. The buffer state does not change.
- R5: A fill whose tag differs from the current epoch is dropped with no effect and no error.
- R6: `occ_lines` equals buffered lines plus reserved lines, and `buf_bytes` equals buffered lines times LINE_BYTES.
- R7: When lines are buffered and `pc_in` is at or beyond the end address of the oldest buffered line, that line is freed at the next edge. At most one line is freed per cycle.
- R8: `word_data` holds the bytes at read pointer +0..+3 (byte 0 in bits [7:0]). It wraps from the last physical byte to the first. `word_valid` is 1 when at least 4 buffered bytes lie at or beyond the read pointer. `word_valid && word_ready` advances the pointer by 4.
- R9: `has_data` is 1 when at least one buffered byte lies at or beyond the read pointer.
- R10: A flush empties all slots, sets the read pointer to `flush_pc`, and restarts fetching at the line of `flush_pc`. It increments the epoch modulo 2^EW and overrides a same-cycle handshake, fill or word accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | output | 1 | A line request is offered |
| req_ready | input | 1 | Memory side takes the request |
| req_addr | output | AW | Line-aligned request address |
| req_tag | output | EW | Epoch attached to the request |
| fill_valid | input | 1 | A line fill is presented |
| fill_addr | input | AW | Address of the filled line |
| fill_tag | input | EW | Epoch returned with the fill |
| fill_data | input | LINE_BYTES*8 | Line data, byte 0 in the low bits |
| word_valid | output | 1 | An instruction word is ready |
| word_ready | input | 1 | Downstream takes the word |
| word_data | output | 32 | Instruction word at the read pointer |
| has_data | output | 1 | Unread buffered bytes remain |
| pc_in | input | AW | Current wavefront program counter |
| flush | input | 1 | Discard everything and redirect |
| flush_pc | input | AW | Redirect address |
| occ_lines | output | $clog2(DEPTH+1) | Buffered plus reserved lines |
| buf_bytes | output | $clog2(DEPTH*LINE_BYTES+1) | Buffered line count times line size |
| order_err | output | 1 | Out-of-order fill flag |

## Verification
A wrong count of buffered or reserved lines shows up at the next sampling point. It appears in `occ_lines`, `buf_bytes` and `req_valid`, and a wrong oldest-reservation pointer shifts `req_addr`. A fill written into the wrong slot, or a read index that fails to wrap, is invisible until the read pointer reaches the affected bytes. At that point `word_data` differs from the address-derived pattern, so fills are made with a per-fill salt that exposes stale or misplaced lines. A stale epoch or a missed out-of-order fill corrupts the state on the same edge. The damage then appears one cycle later as a spurious or missing `order_err`, or as occupancy that has moved.

// File: rtl/wf_fetch_buf.sv
module wf_fetch_buf #(
  parameter int AW = 32,
  parameter int DEPTH = 4,
  parameter int LINE_BYTES = 16,
  parameter int EW = 2
) (
  input  logic                             clk,
  input  logic                             rst_n,
  output logic                             req_valid,
  input  logic                             req_ready,
  output logic [AW-1:0]                    req_addr,
  output logic [EW-1:0]                    req_tag,
  input  logic                             fill_valid,
  input  logic [AW-1:0]                    fill_addr,
  input  logic [EW-1:0]                    fill_tag,
  input  logic [LINE_BYTES*8-1:0]          fill_data,
  output logic                             word_valid,
  input  logic                             word_ready,
  output logic [31:0]                      word_data,
  output logic                             has_data,
  input  logic [AW-1:0]                    pc_in,
  input  logic                             flush,
  input  logic [AW-1:0]                    flush_pc,
  output logic [$clog2(DEPTH+1)-1:0]       occ_lines,
  output logic [$clog2(DEPTH*LINE_BYTES+1)-1:0] buf_bytes,
  output logic                             order_err
);
  localparam int LOG = $clog2(LINE_BYTES);
  localparam int SW = $clog2(DEPTH);
  localparam int LW = AW - LOG;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(DEPTH * LINE_BYTES + 1);

  logic [LINE_BYTES*8-1:0] slot_q [DEPTH];
  logic [LW-1:0] base_q;
  logic [CW-1:0] nbuf_q, nres_q;
  logic [AW-1:0] rd_q;
  logic [EW-1:0] ep_q;
  logic          err_q;

  wire [CW-1:0] occ       = nbuf_q + nres_q;
  wire [LW-1:0] pend_line = base_q + LW'(nbuf_q);
  wire [LW-1:0] tail_line = pend_line + LW'(nres_q);
  wire [LW-1:0] next_base = base_q + LW'(1);
  wire [AW-1:0] buf_end   = {pend_line, {LOG{1'b0}}};
  wire [AW-1:0] base_end  = {next_base, {LOG{1'b0}}};

  wire issue    = req_valid & req_ready & ~flush;
  wire tag_ok   = fill_valid & ~flush & (fill_tag == ep_q);
  wire fill_hit = tag_ok & (nres_q != '0) & (fill_addr[AW-1:LOG] == pend_line);
  wire release_ln = (nbuf_q != '0) & (pc_in >= base_end);
  wire consume  = word_valid & word_ready & ~flush;

  assign req_valid  = occ < CW'(DEPTH);
  assign req_addr   = {tail_line, {LOG{1'b0}}};
  assign req_tag    = ep_q;
  assign word_valid = buf_end >= rd_q + AW'(4);
  assign has_data   = buf_end > rd_q;
  assign occ_lines  = occ;
  assign buf_bytes  = BW'({nbuf_q, {LOG{1'b0}}});
  assign order_err  = err_q;

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      logic [AW-1:0] a;
      a = rd_q + AW'(i);
      word_data[8*i +: 8] = slot_q[a[LOG+SW-1:LOG]][8*a[LOG-1:0] +: 8];
    end
  end

  always_ff @(posedge clk) begin
    if (fill_hit) slot_q[pend_line[SW-1:0]] <= fill_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      nbuf_q <= '0;
      nres_q <= '0;
      rd_q   <= '0;
      ep_q   <= '0;
      err_q  <= 1'b0;
    end else if (flush) begin
      base_q <= flush_pc[AW-1:LOG];
      nbuf_q <= '0;
      nres_q <= '0;
      rd_q   <= flush_pc;
      ep_q   <= ep_q + EW'(1);
      err_q  <= 1'b0;
    end else begin
      base_q <= base_q + LW'(release_ln);
      nbuf_q <= nbuf_q + CW'(fill_hit) - CW'(release_ln);
      nres_q <= nres_q + CW'(issue) - CW'(fill_hit);
      rd_q   <= rd_q + (consume ? AW'(4) : AW'(0));
      err_q  <= tag_ok & ~fill_hit;
    end
  end
endmodule

// File: rtl/wf_fetch_buf_chk.sv
module wf_fetch_buf_chk #(
  parameter int DEPTH = 4,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          fill_valid,
  input logic          flush,
  input logic          word_valid,
  input logic          word_ready,
  input logic [31:0]   word_data,
  input logic          has_data,
  input logic [CW-1:0] occ_lines,
  input logic          order_err
);
  // R6
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ_lines <= CW'(DEPTH));
  // R2
  issue_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && !flush && !fill_valid |=> occ_lines >= $past(occ_lines));
  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> occ_lines == '0 && !word_valid && !has_data);
  // R4
  err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    order_err |-> $past(fill_valid) && !$past(flush));
  // R8
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid && !word_ready && !flush |=> $stable(word_data));
  // R9
  valid_has_chk: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> has_data);
endmodule

bind wf_fetch_buf wf_fetch_buf_chk #(.DEPTH(DEPTH), .CW($clog2(DEPTH+1))) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .fill_valid(fill_valid), .flush(flush), .word_valid(word_valid),
  .word_ready(word_ready), .word_data(word_data), .has_data(has_data),
  .occ_lines(occ_lines), .order_err(order_err));

// File: tb/wf_fetch_buf_tb.sv
`timescale 1ns/1ps
module wf_fetch_buf_tb;
  localparam int AW = 32, DEPTH = 4, LB = 16, EW = 2, LOG = 4, TOT = DEPTH * LB;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid, req_ready = 1'b0;
  logic [AW-1:0] req_addr;
  logic [EW-1:0] req_tag;
  logic fill_valid = 1'b0;
  logic [AW-1:0] fill_addr = '0;
  logic [EW-1:0] fill_tag = '0;
  logic [LB*8-1:0] fill_data = '0;
  logic word_valid, word_ready = 1'b0;
  logic [31:0] word_data;
  logic has_data;
  logic [AW-1:0] pc_in = '0;
  logic flush = 1'b0;
  logic [AW-1:0] flush_pc = '0;
  logic [2:0] occ_lines;
  logic [6:0] buf_bytes;
  logic order_err;

  always #2.5 clk = ~clk;

  wf_fetch_buf #(.AW(AW), .DEPTH(DEPTH), .LINE_BYTES(LB), .EW(EW)) u_dut (.*);

  int tests = 0, fails = 0;
  bit done = 1'b0;
  int unsigned m_base = 0, m_nb = 0, m_nr = 0, m_rd = 0, m_ep = 0;
  bit m_err = 1'b0;
  int unsigned line_salt [int unsigned];
  int unsigned q_addr [$];
  int unsigned q_tag [$];
  int unsigned salt_ctr = 1;
  int wrap_cnt = 0, stale_cnt = 0, inj_cnt = 0;
  bit inj_pend = 1'b0;

  function automatic logic [7:0] byte_of(int unsigned a, int unsigned s);
    return 8'((a * 13 + s * 29 + (a >> 4)) & 255);
  endfunction

  task automatic check(bit ok, string what, longint unsigned act, longint unsigned exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  task automatic compare(string pre);
    int unsigned occ = m_nb + m_nr;
    int unsigned bend = (m_base + m_nb) << LOG;
    bit rv = occ < DEPTH;
    bit wv = bend >= m_rd + 4;
    bit hd = bend > m_rd;
    check(occ_lines == occ, {pre, "R6 R7 occupancy"}, occ_lines, occ);
    check(buf_bytes == m_nb * LB, {pre, "R6 buffered bytes"}, buf_bytes, m_nb * LB);
    check(req_valid == rv, {pre, "R2 req_valid"}, req_valid, rv);
    if (rv) check(req_addr == ((m_base + occ) << LOG), {pre, "R2 req_addr"}, req_addr, (m_base + occ) << LOG);
    check(req_tag == EW'(m_ep), {pre, "R10 epoch tag"}, req_tag, m_ep);
    check(has_data == hd, {pre, "R9 has_data"}, has_data, hd);
    check(word_valid == wv, {pre, "R8 word_valid"}, word_valid, wv);
    check(order_err == m_err, {pre, "R4 order_err"}, order_err, m_err);
    if (wv) begin
      logic [31:0] w;
      for (int i = 0; i < 4; i++) begin
        int unsigned a = m_rd + i;
        w[8*i +: 8] = byte_of(a, line_salt[a >> LOG]);
      end
      check(word_data == w, {pre, "R3 R8 word_data"}, word_data, w);
    end
  endtask

  task automatic drive_and_step(int cyc);
    int unsigned occ = m_nb + m_nr;
    bit rv = occ < DEPTH;
    bit wv = ((m_base + m_nb) << LOG) >= m_rd + 4;
    bit hs, fhit, rel, ferr;
    int unsigned fl;
    flush = (cyc == 300) || (cyc == 700) || (cyc == 1100) || (cyc == 1600);
    case (cyc)
      300: flush_pc = TOT - 2;
      700: flush_pc = 32'h1003;
      1100: flush_pc = 32'h2FFD;
      default: flush_pc = 32'h40;
    endcase
    if (cyc == 200 || cyc == 500 || cyc == 900 || cyc == 1400) inj_pend = 1'b1;
    req_ready = ($urandom % 4) != 0;
    word_ready = ($urandom % 3) != 0;
    pc_in = m_rd;
    fill_valid = 1'b0;
    if (q_addr.size() > 0) begin
      if (inj_pend && q_tag[0] == m_ep && !flush) begin
        fill_valid = 1'b1;
        fill_addr = q_addr[0] + LB;
        fill_tag = EW'(q_tag[0]);
        inj_pend = 1'b0;
        inj_cnt++;
      end else if (($urandom % 2) == 0) begin
        fill_valid = 1'b1;
        fill_addr = q_addr.pop_front();
        fill_tag = EW'(q_tag.pop_front());
        if (fill_tag != EW'(m_ep) && !flush) stale_cnt++;
      end
      if (fill_valid) begin
        for (int b = 0; b < LB; b++) fill_data[8*b +: 8] = byte_of(fill_addr + b, salt_ctr);
      end
    end
    hs = rv && req_ready;
    if (hs) begin
      q_addr.push_back((m_base + occ) << LOG);
      q_tag.push_back(m_ep);
    end
    if (flush) begin
      m_base = flush_pc >> LOG; m_nb = 0; m_nr = 0; m_rd = flush_pc;
      m_ep = (m_ep + 1) % 4; m_err = 1'b0;
    end else begin
      fl = fill_addr >> LOG;
      fhit = fill_valid && fill_tag == EW'(m_ep) && m_nr > 0 && fl == m_base + m_nb;
      ferr = fill_valid && fill_tag == EW'(m_ep) && !fhit;
      rel = m_nb > 0 && pc_in >= ((m_base + 1) << LOG);
      if (fhit) line_salt[fl] = salt_ctr;
      if (wv && word_ready) begin
        if ((m_rd % TOT) > TOT - 4) wrap_cnt++;
        m_rd += 4;
      end
      m_base += rel;
      m_nb = m_nb + fhit - rel;
      m_nr = m_nr + hs - fhit;
      m_err = ferr;
    end
    if (fill_valid) salt_ctr++;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    compare("R1 reset: ");
    rst_n = 1'b1;
    drive_and_step(0);
    for (int c = 1; c < 2000; c++) begin
      @(negedge clk);
      compare("");
      drive_and_step(c);
    end
    @(negedge clk);
    compare("");
    check(wrap_cnt > 0, "R8 word wrapped across array end", wrap_cnt, 1);
    check(stale_cnt > 0, "R5 stale fill dropped", stale_cnt, 1);
    check(inj_cnt > 0, "R4 out-of-order fill injected", inj_cnt, 1);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule